// File: doc/BRIEF.md
# Trace Channel Console

The block is a debug trace peripheral with two address regions. The first is a set of 32-bit control registers: a fixed revision word, a configuration register whose write can also start a soft reset, interrupt status and enable, clock control and serial configuration. Software uses this window to set up the unit and to service its interrupt line. Interrupt status bits are set by a vector of event inputs and are cleared by software.

The second region is a 64 KiB channel window. Each 64-byte slice of it is one trace channel. A byte written to a channel becomes a character on a valid/ready console stream. A few cases are translated. Channel-open marker bytes are dropped. A zero byte becomes a line feed. Any write to the dedicated control channel becomes a carriage return. An access that cannot be served in either window pulses an error output.

Top module: `trace_console`

## Requirements
- R1: After reset every stored register reads 0, `char_valid` is low, `irq` is low and `bad_access` is low.
- R2: Register offset 0x00 always reads 0x00000010, and a write to it changes nothing.
- R3: A write to offset 0x10 stores bits 7:0 of the data with bit 0 forced to 0. If data bit 1 is set, the write first clears configuration, interrupt status, interrupt enable, clock control and serial configuration, and then stores the masked value.
- R4: At offset 0x18, each 1 on `irq_evt` sets the matching status bit. A write of 1 to a bit clears it. When a set and a clear hit the same bit in the same cycle, the set wins.
- R5: Offset 0x1C keeps bits 15:0 of a written value and reads back zero-extended.
- R6: `irq` is high exactly when the stored status ANDed with the stored enable is nonzero.
- R7: Offsets 0x2C and 0x30 each keep bits 7:0 of a written value. Offset 0x14 always reads 0, and a write to it has no effect and is not an error.
- R8: A register access to offset 0x24, to 0x28, to any other undecoded offset, or to an offset with bits 1:0 nonzero reads 0 and raises `bad_access` for the one cycle after the access.
- R9: The channel number is `chn_addr` shifted right by 6. Any byte write to channel 253 emits 0x0D, whatever the data.
- R10: A byte write to any other channel emits nothing for data 0xC0 or 0xC3, emits 0x0A for data 0x00, and otherwise emits the data byte.
- R11: Only `chn_size` = 0 (byte) writes are accepted. A write of size 1 or 2 and any `chn_rd` emit nothing and raise `bad_access` for the next cycle.
- R12: An emitted character shows up on `char_data` with `char_valid` high in the cycle after the accepted write. While `char_valid` is high and `char_ready` is low, `chn_stall` is high, the character stays unchanged and channel writes are not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_rd | input | 1 | Control register read strobe |
| reg_addr | input | 8 | Control register byte offset |
| reg_wdata | input | 32 | Control register write data |
| reg_rdata | output | 32 | Control register read data (combinational) |
| irq_evt | input | 16 | Interrupt event inputs, one per status bit |
| irq | output | 1 | Interrupt request |
| chn_wr | input | 1 | Channel window write strobe |
| chn_rd | input | 1 | Channel window read strobe (always an error) |
| chn_addr | input | 16 | Channel window byte offset |
| chn_size | input | 2 | Access size: 0 byte, 1 half-word, 2 word |
| chn_wdata | input | 8 | Channel write data byte |
| chn_stall | output | 1 | Write not accepted; hold it |
| char_valid | output | 1 | Console character valid |
| char_data | output | 8 | Console character |
| char_ready | input | 1 | Console sink ready |
| bad_access | output | 1 | One-cycle pulse after a bad access |

## Verification
All 256 data bytes are written to an ordinary channel. This separates the two marker values and the zero translation from plain pass-through. All 1024 channels are written with one fixed byte, each at a different offset inside its slice, so a wrong shift or a wrong control-channel match shows up as a misplaced carriage return. Every register offset is read against values computed in the bench, which separates decoded registers from error offsets. Targeted sequences cover soft reset, write-one-to-clear racing an event, the enable mask, wide or read accesses to the channel window, and back-pressure from the console sink.

// File: rtl/trace_console_pkg.sv
// Package: shared constants and the character translation for the trace console.
// Assumes byte offsets in the register window and the 8-bit data stream.
package trace_console_pkg;
    localparam logic [7:0] OFF_REV  = 8'h00;
    localparam logic [7:0] OFF_CFG  = 8'h10;
    localparam logic [7:0] OFF_SYS  = 8'h14;
    localparam logic [7:0] OFF_STAT = 8'h18;
    localparam logic [7:0] OFF_EN   = 8'h1C;
    localparam logic [7:0] OFF_CLK  = 8'h2C;
    localparam logic [7:0] OFF_SER  = 8'h30;

    localparam logic [31:0] REV_VALUE = 32'h0000_0010;
    localparam logic [7:0]  CFG_MASK  = 8'hFE;

    localparam logic [7:0] CH_CR     = 8'h0D;
    localparam logic [7:0] CH_LF     = 8'h0A;
    localparam logic [7:0] MARK_OPEN = 8'hC0;
    localparam logic [7:0] MARK_ALT  = 8'hC3;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    // Character for a data byte on an ordinary channel (valid only if not a marker)
    function automatic logic [7:0] plain_char(input logic [7:0] d);
        return (d == 8'h00) ? CH_LF : d;
    endfunction

    function automatic logic is_marker(input logic [7:0] d);
        return (d == MARK_OPEN) || (d == MARK_ALT);
    endfunction
endpackage

// File: rtl/tc_ctrl_regs.sv
// Module: control register window. It decodes word offsets, holds configuration,
// interrupt status/enable, clock and serial settings, and drives the interrupt.
// Assumes single-cycle strobes and combinational read data.
module tc_ctrl_regs
    import trace_console_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int IRQ_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IRQ_W-1:0]  evt,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic              bad
);
    logic [7:0]       cfg_q, clk_q, ser_q;
    logic [IRQ_W-1:0] stat_q, en_q, clr_mask;
    logic sel_rev, sel_cfg, sel_sys, sel_st, sel_en, sel_clk, sel_ser, known, srst;
    logic unused_wdata;

    assign unused_wdata = ^wdata[DATA_W-1:IRQ_W];

    // Offset decode; a misaligned offset matches nothing
    always_comb begin
        sel_rev = (addr == OFF_REV);
        sel_cfg = (addr == OFF_CFG);
        sel_sys = (addr == OFF_SYS);
        sel_st  = (addr == OFF_STAT);
        sel_en  = (addr == OFF_EN);
        sel_clk = (addr == OFF_CLK);
        sel_ser = (addr == OFF_SER);
        known   = sel_rev | sel_cfg | sel_sys | sel_st | sel_en | sel_clk | sel_ser;
        bad     = (wr | rd) & ~known;
        srst    = wr & sel_cfg & wdata[1];
        clr_mask = (wr & sel_st) ? wdata[IRQ_W-1:0] : '0;
    end

    // Register state with soft reset and event-over-clear priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            clk_q  <= '0;
            ser_q  <= '0;
            stat_q <= '0;
            en_q   <= '0;
        end else if (srst) begin
            cfg_q  <= wdata[7:0] & CFG_MASK;
            clk_q  <= '0;
            ser_q  <= '0;
            stat_q <= '0;
            en_q   <= '0;
        end else begin
            if (wr & sel_cfg) cfg_q <= wdata[7:0] & CFG_MASK;
            if (wr & sel_clk) clk_q <= wdata[7:0];
            if (wr & sel_ser) ser_q <= wdata[7:0];
            if (wr & sel_en)  en_q  <= wdata[IRQ_W-1:0];
            stat_q <= (stat_q & ~clr_mask) | evt;
        end
    end

    // Read multiplexer; bad and non-read cycles return zero
    always_comb begin
        rdata = '0;
        if (rd) begin
            unique case (1'b1)
                sel_rev: rdata = REV_VALUE;
                sel_cfg: rdata = DATA_W'(cfg_q);
                sel_st:  rdata = DATA_W'(stat_q);
                sel_en:  rdata = DATA_W'(en_q);
                sel_clk: rdata = DATA_W'(clk_q);
                sel_ser: rdata = DATA_W'(ser_q);
                default: rdata = '0;
            endcase
        end
    end

    // Interrupt from stored status and enable
    assign irq = |(stat_q & en_q);
endmodule

// File: rtl/tc_chan_decode.sv
// Module: channel window decoder. It turns an address and data byte into an
// optional console character and flags accesses the window cannot serve.
// Assumes one access per cycle; acceptance under back-pressure is gated outside.
module tc_chan_decode
    import trace_console_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int CH_SHIFT = 6,
    parameter int CTRL_CH  = 253
) (
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic [7:0]        data,
    output logic              emit,
    output logic [7:0]        ch_out,
    output logic              bad
);
    localparam int CH_W = ADDR_W - CH_SHIFT;

    logic [CH_W-1:0] chan;
    logic is_byte, is_ctrl;
    logic unused_low;

    assign chan       = addr[ADDR_W-1:CH_SHIFT];
    assign unused_low = ^addr[CH_SHIFT-1:0];

    // Translate the write and classify the access
    always_comb begin
        is_byte = (size == SZ_BYTE);
        is_ctrl = (chan == CH_W'(CTRL_CH));
        bad     = rd | (wr & ~is_byte);
        emit    = wr & is_byte & (is_ctrl | ~is_marker(data));
        ch_out  = is_ctrl ? CH_CR : plain_char(data);
    end
endmodule

// File: rtl/tc_char_out.sv
// Module: one-entry console output register with valid/ready hand-off.
// Assumes the caller loads only when busy is low.
module tc_char_out #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] din,
    input  logic          ready,
    output logic          valid,
    output logic [DW-1:0] dout,
    output logic          busy
);
    assign busy = valid & ~ready;

    // Hold while stalled, otherwise take the new character or go idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            dout  <= '0;
        end else if (!busy) begin
            valid <= load;
            if (load) dout <= din;
        end
    end
endmodule

// File: rtl/trace_console.sv
// Module: trace console top. It joins the control window, the channel decoder and
// the console output stage, and registers the bad-access pulse.
// Assumes a single clock domain and synchronous active-low reset.
module trace_console #(
    parameter int REG_AW   = 8,
    parameter int REG_DW   = 32,
    parameter int IRQ_W    = 16,
    parameter int CHN_AW   = 16,
    parameter int CH_SHIFT = 6,
    parameter int CTRL_CH  = 253
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    input  logic [IRQ_W-1:0]  irq_evt,
    output logic              irq,
    input  logic              chn_wr,
    input  logic              chn_rd,
    input  logic [CHN_AW-1:0] chn_addr,
    input  logic [1:0]        chn_size,
    input  logic [7:0]        chn_wdata,
    output logic              chn_stall,
    output logic              char_valid,
    output logic [7:0]        char_data,
    input  logic              char_ready,
    output logic              bad_access
);
    logic reg_bad, chn_bad, emit, busy;
    logic [7:0] emit_char;

    tc_ctrl_regs #(.ADDR_W(REG_AW), .DATA_W(REG_DW), .IRQ_W(IRQ_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
        .wdata(reg_wdata), .evt(irq_evt), .rdata(reg_rdata), .irq(irq), .bad(reg_bad)
    );

    tc_chan_decode #(.ADDR_W(CHN_AW), .CH_SHIFT(CH_SHIFT), .CTRL_CH(CTRL_CH)) u_dec (
        .wr(chn_wr), .rd(chn_rd), .addr(chn_addr), .size(chn_size), .data(chn_wdata),
        .emit(emit), .ch_out(emit_char), .bad(chn_bad)
    );

    tc_char_out #(.DW(8)) u_out (
        .clk(clk), .rst_n(rst_n), .load(emit & ~busy), .din(emit_char),
        .ready(char_ready), .valid(char_valid), .dout(char_data), .busy(busy)
    );

    assign chn_stall = busy;

    // One-cycle error pulse for either window
    always_ff @(posedge clk) begin
        if (!rst_n) bad_access <= 1'b0;
        else        bad_access <= reg_bad | chn_bad;
    end
endmodule

// File: rtl/trace_console_chk.sv
// Module: protocol checker for the trace console, bound to every instance.
// Assumes the default register offsets and control channel 253.
module trace_console_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic        reg_rd,
    input logic [7:0]  reg_addr,
    input logic        srst_bit,
    input logic [31:0] reg_rdata,
    input logic [15:0] irq_evt,
    input logic        irq,
    input logic        chn_wr,
    input logic        chn_rd,
    input logic [9:0]  chn_chan,
    input logic [1:0]  chn_size,
    input logic        chn_stall,
    input logic        char_valid,
    input logic [7:0]  char_data,
    input logic        char_ready,
    input logic        bad_access
);
    // R2: revision constant on every read
    assert_rev_const_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd && reg_addr == 8'h00 |-> reg_rdata == 32'h10);

    // R3: soft reset leaves no interrupt pending
    assert_srst_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_addr == 8'h10 && srst_bit && irq_evt == 16'h0 |=> !irq);

    // R8: bad register read returns zero and flags the next cycle
    assert_bad_rd_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd && reg_addr == 8'h24 |-> reg_rdata == 32'h0);
    assert_bad_rd_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd && reg_addr == 8'h28 |=> bad_access);

    // R9: control channel yields carriage return
    assert_ctrl_cr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        chn_wr && chn_size == 2'd0 && chn_chan == 10'd253 && !chn_stall
        |=> char_valid && char_data == 8'h0D);

    // R11: channel reads are errors
    assert_chn_rd_bad_R11: assert property (@(posedge clk) disable iff (!rst_n)
        chn_rd |=> bad_access);

    // R12: stalled character is held
    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid && !char_ready |=> char_valid && $stable(char_data));
endmodule

bind trace_console trace_console_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .srst_bit(reg_wdata[1]), .reg_rdata(reg_rdata),
    .irq_evt(irq_evt), .irq(irq), .chn_wr(chn_wr), .chn_rd(chn_rd),
    .chn_chan(chn_addr[15:6]), .chn_size(chn_size), .chn_stall(chn_stall),
    .char_valid(char_valid), .char_data(char_data), .char_ready(char_ready),
    .bad_access(bad_access)
);

// File: tb/trace_console_tb.sv
module trace_console_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [7:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic [15:0] irq_evt = 0;
    logic        irq;
    logic        chn_wr = 0, chn_rd = 0;
    logic [15:0] chn_addr = 0;
    logic [1:0]  chn_size = 0;
    logic [7:0]  chn_wdata = 0;
    logic        chn_stall, char_valid, char_ready = 1'b1, bad_access;
    logic [7:0]  char_data;

    int errs = 0, checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trace_console u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_evt(irq_evt), .irq(irq), .chn_wr(chn_wr), .chn_rd(chn_rd),
        .chn_addr(chn_addr), .chn_size(chn_size), .chn_wdata(chn_wdata),
        .chn_stall(chn_stall), .char_valid(char_valid), .char_data(char_data),
        .char_ready(char_ready), .bad_access(bad_access)
    );

    // Bench model of the stored registers
    logic [7:0]  m_cfg = 0, m_clk = 0, m_ser = 0;
    logic [15:0] m_st = 0, m_en = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d, output logic b);
        reg_rd = 1; reg_addr = a;
        #1 d = reg_rdata;
        tick();
        b = bad_access;
        reg_rd = 0;
    endtask

    task automatic wr_chn(input logic [15:0] a, input logic [7:0] d, input logic [1:0] s);
        chn_wr = 1; chn_addr = a; chn_wdata = d; chn_size = s;
        tick();
        chn_wr = 0;
    endtask

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        case (a)
            8'h00: return 32'h10;
            8'h10: return {24'h0, m_cfg};
            8'h18: return {16'h0, m_st};
            8'h1C: return {16'h0, m_en};
            8'h2C: return {24'h0, m_clk};
            8'h30: return {24'h0, m_ser};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic exp_bad(input logic [7:0] a);
        return !(a == 8'h00 || a == 8'h10 || a == 8'h14 || a == 8'h18 ||
                 a == 8'h1C || a == 8'h2C || a == 8'h30);
    endfunction

    // Expected {valid, char} for a byte write
    function automatic logic [8:0] exp_char(input int ch, input logic [7:0] d);
        if (ch == 253) return {1'b1, 8'h0D};
        if (d == 8'hC0 || d == 8'hC3) return 9'h000;
        if (d == 8'h00) return {1'b1, 8'h0A};
        return {1'b1, d};
    endfunction

    task automatic sweep_regs(input string req);
        logic [31:0] d;
        logic b;
        for (int a = 0; a < 256; a += 4) begin
            rd_reg(8'(a), d, b);
            chk(req, d, exp_rd(8'(a)));
            chk("R8", {31'h0, b}, {31'h0, exp_bad(8'(a))});
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errs++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks + 1);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic b;
        logic [8:0] e;
        repeat (3) tick();
        rst_n = 1;
        // R1: reset state
        chk("R1", {29'h0, char_valid, irq, bad_access}, 32'h0);
        sweep_regs("R1");

        // R2: revision ignores writes
        wr_reg(8'h00, 32'hFFFF_FFFF);
        rd_reg(8'h00, d, b);
        chk("R2", d, 32'h10);

        // R7: clock/serial masks, status reg read-only and not bad
        wr_reg(8'h2C, 32'h1234_56AB); m_clk = 8'hAB;
        wr_reg(8'h30, 32'hFFFF_FF34); m_ser = 8'h34;
        reg_wr = 1; reg_addr = 8'h14; reg_wdata = 32'hFFFF_FFFF;
        tick(); reg_wr = 0;
        chk("R7", {31'h0, bad_access}, 32'h0);
        rd_reg(8'h14, d, b);
        chk("R7", d, 32'h0);

        // R3: config mask without soft reset keeps other registers
        wr_reg(8'h10, 32'h0000_0105); m_cfg = 8'h04;
        sweep_regs("R3");

        // R4/R5/R6: events, enable mask, interrupt
        irq_evt = 16'h0008; tick(); irq_evt = 0; m_st = 16'h0008;
        chk("R6", {31'h0, irq}, 32'h0);
        wr_reg(8'h1C, 32'hFFFF_0008); m_en = 16'h0008;
        rd_reg(8'h1C, d, b);
        chk("R5", d, 32'h0000_0008);
        chk("R6", {31'h0, irq}, 32'h1);
        wr_reg(8'h1C, 32'h0000_0010); m_en = 16'h0010;
        chk("R6", {31'h0, irq}, 32'h0);
        wr_reg(8'h1C, 32'h0000_0008); m_en = 16'h0008;
        wr_reg(8'h18, 32'h0000_0008); m_st = 0;
        chk("R4", {31'h0, irq}, 32'h0);
        // R4: set wins over clear in the same cycle
        irq_evt = 16'h0020; reg_wr = 1; reg_addr = 8'h18; reg_wdata = 32'h20;
        tick(); reg_wr = 0; irq_evt = 0; m_st = 16'h0020;
        rd_reg(8'h18, d, b);
        chk("R4", d, 32'h20);
        irq_evt = 16'h0008; tick(); irq_evt = 0; m_st = 16'h0028;
        chk("R6", {31'h0, irq}, 32'h1);
        sweep_regs("R4");

        // R3: soft reset clears everything then stores masked value
        wr_reg(8'h10, 32'h0000_00FF);
        m_cfg = 8'hFE; m_clk = 0; m_ser = 0; m_st = 0; m_en = 0;
        chk("R3", {31'h0, irq}, 32'h0);
        sweep_regs("R3");

        // R8: misaligned register access
        rd_reg(8'h11, d, b);
        chk("R8", {d[30:0], b}, 32'h1);

        // R10: byte sweep on two ordinary channels
        for (int ch = 0; ch < 2; ch++) begin
            for (int v = 0; v < 256; v++) begin
                int cn;
                cn = (ch == 0) ? 239 : 7;
                wr_chn(16'(cn << 6) | 16'(v % 64), 8'(v), 2'd0);
                e = exp_char(cn, 8'(v));
                chk("R10", {23'h0, char_valid, char_data & {8{char_valid}}}, {23'h0, e});
            end
        end

        // R9: channel sweep with a fixed byte at varying slice offsets
        for (int ch = 0; ch < 1024; ch++) begin
            wr_chn(16'(ch << 6) | 16'(ch % 64), 8'h41, 2'd0);
            e = exp_char(ch, 8'h41);
            chk("R9", {23'h0, char_valid, char_data}, {23'h0, e});
        end
        wr_chn(16'd253 << 6, 8'hC0, 2'd0);
        chk("R9", {23'h0, char_valid, char_data}, {23'h0, 9'h10D});

        // R11: wide writes and reads
        for (int s = 1; s < 3; s++) begin
            wr_chn(16'h0100, 8'h41, 2'(s));
            chk("R11", {30'h0, char_valid, bad_access}, 32'h1);
        end
        chn_rd = 1; chn_addr = 16'h0040; tick(); chn_rd = 0;
        chk("R11", {30'h0, char_valid, bad_access}, 32'h1);

        // R12: back-pressure holds the character and blocks writes
        char_ready = 0;
        wr_chn(16'h0080, 8'h41, 2'd0);
        chk("R12", {22'h0, chn_stall, char_valid, char_data}, {22'h0, 2'b11, 8'h41});
        wr_chn(16'h0080, 8'h42, 2'd0);
        chk("R12", {22'h0, chn_stall, char_valid, char_data}, {22'h0, 2'b11, 8'h41});
        char_ready = 1;
        tick();
        chk("R12", {30'h0, chn_stall, char_valid}, 32'h0);

        // R1: hard reset returns to idle
        wr_chn(16'h0080, 8'h43, 2'd0);
        rst_n = 0; tick(); rst_n = 1;
        m_cfg = 0;
        chk("R1", {29'h0, char_valid, irq, bad_access}, 32'h0);
        sweep_regs("R1");

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule